// File: doc/BRIEF.md
# Inter-Access Idle Cycle Inserter

This block sits inside an external bus controller. It works out how many idle bus cycles must separate the end of one external access from the start of the next. The goal is to let a slow device stop driving the data lines before another transfer begins. The controller reports each access in the last cycle in which its chip select is active. It then presents the descriptor of the pending next access. The block answers combinationally with the required idle count, the number of idle cycles still owed, and a stall that holds off the next chip-select assertion.

The count comes from several sources:

- A category count, held per chip-select space and chosen by the direction pair of the two accesses. Read-then-write and read-then-read pairs are further split by whether both accesses hit the same space.
- A common count that applies after a DMA single-address transfer in which an external device drove the data. A common scope bit controls when this DMA count is used.
- A per-space wait-mode bit that can force a minimum of one idle cycle.

When several of these apply, the largest value wins. The block counts idle cycles that have already passed since the previous access ended, so a bus that has sat idle long enough causes no stall.

Top module: `iai_idle_inserter`

## Requirements
- R1: When the ended access was a write, the count is the write-then-read field of the ended space if the next access reads (`nxt_write_i`=0), or its write-then-write field if the next access writes. Space s occupies bits [3s+2:3s] of every per-space count port.
- R2: When the ended access was a read and the next access writes, the count is the read-then-write same-space field if `nxt_space_i` equals the ended space, and the different-space field otherwise.
- R3: When both accesses are reads, the count is the read-then-read same-space field if the spaces match, and the different-space field otherwise.
- R4: Per-space fields and the wait-mode bit are always taken from the space of the access that ended, never from the next access's space.
- R5: With `cfg_dma_all_i`=0, the DMA count `cfg_dma_idle_i` applies after an ended access flagged `end_dma_ext_i` only when `nxt_dev_out_i`=1.
- R6: With `cfg_dma_all_i`=1, the DMA count applies after a flagged access whatever the next access is.
- R7: When the wait-mode bit (bit s of `cfg_wait_mode_i`) of the ended space is 0, the count is at least 1.
- R8: When several rules apply, `idle_cnt_o` is the largest of their counts.
- R9: After `end_valid_i` in cycle T with a count N, `stall_o` (while `req_i`=1) is high in cycles T+1 through T+N and low from T+N+1. A count of 0 produces no stall at all.
- R10: After reset and before the first `end_valid_i`, `idle_cnt_o`, `remain_o` and `stall_o` are 0.
- R11: Idle cycles already elapsed since the end count toward the requirement. The elapsed count saturates, so a long idle bus never stalls.
- R12: `remain_o` equals the count minus the cycles elapsed since the end (floored at 0), and it drops by one per cycle while the descriptor is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| end_valid_i | input | 1 | Last cycle of an access with its chip select active |
| end_write_i | input | 1 | Ended access was a write |
| end_space_i | input | 3 | Space index of the ended access |
| end_dma_ext_i | input | 1 | Ended access was a DMA single-address transfer with external data drive |
| req_i | input | 1 | A next access is waiting to assert its chip select |
| nxt_write_i | input | 1 | Next access is a write |
| nxt_space_i | input | 3 | Space index of the next access |
| nxt_dev_out_i | input | 1 | Next access is data output from another device |
| cfg_wr_idle_i | input | 24 | Per-space write-then-read count |
| cfg_ww_idle_i | input | 24 | Per-space write-then-write count |
| cfg_rw_same_i | input | 24 | Per-space read-then-write count, same space |
| cfg_rw_diff_i | input | 24 | Per-space read-then-write count, different space |
| cfg_rr_same_i | input | 24 | Per-space read-then-read count, same space |
| cfg_rr_diff_i | input | 24 | Per-space read-then-read count, different space |
| cfg_wait_mode_i | input | 8 | Per-space wait-mode bit; 0 forces at least one idle cycle |
| cfg_dma_idle_i | input | 3 | Common DMA idle count |
| cfg_dma_all_i | input | 1 | DMA count scope: 1 applies it before any next access |
| stall_o | output | 1 | Hold off the next chip-select assertion |
| idle_cnt_o | output | 3 | Selected idle count for the current pair |
| remain_o | output | 3 | Idle cycles still owed |

## Verification
Three outputs are combinational functions of the current next-access inputs and of state registered at the clock edge that closes the ended access. Because of this, each result is due in the same cycle as the next-access stimulus and one cycle after `end_valid_i`. The bench drives inputs at the falling edge and compares all three outputs one time unit later, before the next rising edge. It then advances its own elapsed-cycle model at the rising edge, so each comparison uses exactly the registers the design holds in that cycle. Directed sequences hold a descriptor across a full stall to observe the per-cycle countdown and the release cycle, and they leave the bus idle past saturation before raising a request.

// File: rtl/iai_pkg.sv
package iai_pkg;
  localparam int unsigned NUM_CAT = 6;

  // Index into the per-category field table
  typedef enum logic [2:0] {
    TR_WR      = 3'd0,
    TR_WW      = 3'd1,
    TR_RW_SAME = 3'd2,
    TR_RW_DIFF = 3'd3,
    TR_RR_SAME = 3'd4,
    TR_RR_DIFF = 3'd5
  } trans_e;
endpackage

// File: rtl/iai_field_mux.sv
module iai_field_mux #(
  parameter int unsigned NUM = 8,
  parameter int unsigned W   = 3,
  localparam int unsigned SW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic [NUM*W-1:0] tbl_i,
  input  logic [SW-1:0]    idx_i,
  output logic [W-1:0]     val_o
);
  always_comb begin
    val_o = '0;
    for (int i = 0; i < NUM; i++) begin
      if (idx_i == SW'(i)) val_o = tbl_i[i*W +: W];
    end
  end
endmodule

// File: rtl/iai_rule_sel.sv
module iai_rule_sel
  import iai_pkg::*;
#(
  parameter int unsigned W = 3
) (
  input  logic                  prev_write_i,
  input  logic                  prev_dma_i,
  input  logic                  prev_wm_i,
  input  logic                  same_space_i,
  input  logic                  nxt_write_i,
  input  logic                  nxt_dev_out_i,
  input  logic                  dma_all_i,
  input  logic [W-1:0]          dma_idle_i,
  input  logic [NUM_CAT-1:0][W-1:0] fld_i,
  output logic [W-1:0]          need_o,
  output logic                  dma_hit_o,
  output logic [2:0]            cat_o
);
  trans_e       cat;
  logic [W-1:0] base, with_dma;

  always_comb begin
    unique case ({prev_write_i, nxt_write_i})
      2'b10:   cat = TR_WR;
      2'b11:   cat = TR_WW;
      2'b01:   cat = same_space_i ? TR_RW_SAME : TR_RW_DIFF;
      default: cat = same_space_i ? TR_RR_SAME : TR_RR_DIFF;
    endcase
  end

  assign base      = fld_i[cat];
  assign dma_hit_o = prev_dma_i & (dma_all_i | nxt_dev_out_i);
  assign with_dma  = (dma_hit_o && dma_idle_i > base) ? dma_idle_i : base;
  // Wait-mode clear: at least one idle cycle
  assign need_o    = (!prev_wm_i && with_dma == '0) ? W'(1) : with_dma;
  assign cat_o     = cat;
endmodule

// File: rtl/iai_gap_ctr.sv
module iai_gap_ctr #(
  parameter int unsigned SW = 3,
  parameter int unsigned W  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          end_valid_i,
  input  logic          end_write_i,
  input  logic [SW-1:0] end_space_i,
  input  logic          end_dma_i,
  output logic          prev_vld_o,
  output logic          prev_write_o,
  output logic [SW-1:0] prev_space_o,
  output logic          prev_dma_o,
  output logic [W-1:0]  gap_o
);
  localparam logic [W-1:0] GAP_MAX = {W{1'b1}};

  logic [W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_vld_o   <= 1'b0;
      prev_write_o <= 1'b0;
      prev_space_o <= '0;
      prev_dma_o   <= 1'b0;
      gap_q        <= '0;
    end else if (end_valid_i) begin
      prev_vld_o   <= 1'b1;
      prev_write_o <= end_write_i;
      prev_space_o <= end_space_i;
      prev_dma_o   <= end_dma_i;
      gap_q        <= '0;
    end else if (gap_q != GAP_MAX) begin
      gap_q <= gap_q + W'(1);
    end
  end

  assign gap_o = gap_q;

  assert_gap_sat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_q == GAP_MAX && !end_valid_i) |=> gap_q == GAP_MAX);
  assert_gap_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_valid_i |=> (gap_q == '0 && prev_vld_o));
endmodule

// File: rtl/iai_idle_inserter.sv
module iai_idle_inserter
  import iai_pkg::*;
#(
  parameter int unsigned NUM_SPACES = 8,
  parameter int unsigned IDLE_W     = 3,
  localparam int unsigned SW    = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1,
  localparam int unsigned TBL_W = NUM_SPACES * IDLE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  end_valid_i,
  input  logic                  end_write_i,
  input  logic [SW-1:0]         end_space_i,
  input  logic                  end_dma_ext_i,
  input  logic                  req_i,
  input  logic                  nxt_write_i,
  input  logic [SW-1:0]         nxt_space_i,
  input  logic                  nxt_dev_out_i,
  input  logic [TBL_W-1:0]      cfg_wr_idle_i,
  input  logic [TBL_W-1:0]      cfg_ww_idle_i,
  input  logic [TBL_W-1:0]      cfg_rw_same_i,
  input  logic [TBL_W-1:0]      cfg_rw_diff_i,
  input  logic [TBL_W-1:0]      cfg_rr_same_i,
  input  logic [TBL_W-1:0]      cfg_rr_diff_i,
  input  logic [NUM_SPACES-1:0] cfg_wait_mode_i,
  input  logic [IDLE_W-1:0]     cfg_dma_idle_i,
  input  logic                  cfg_dma_all_i,
  output logic                  stall_o,
  output logic [IDLE_W-1:0]     idle_cnt_o,
  output logic [IDLE_W-1:0]     remain_o
);
  logic              prev_vld, prev_write, prev_dma;
  logic [SW-1:0]     prev_space;
  logic [IDLE_W-1:0] gap;
  logic [NUM_CAT-1:0][TBL_W-1:0]  tbl;
  logic [NUM_CAT-1:0][IDLE_W-1:0] fld;
  logic              wm_sel, dma_hit;
  logic [IDLE_W-1:0] need;
  logic [2:0]        cat;

  iai_gap_ctr #(.SW(SW), .W(IDLE_W)) u_gap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .end_valid_i  (end_valid_i),
    .end_write_i  (end_write_i),
    .end_space_i  (end_space_i),
    .end_dma_i    (end_dma_ext_i),
    .prev_vld_o   (prev_vld),
    .prev_write_o (prev_write),
    .prev_space_o (prev_space),
    .prev_dma_o   (prev_dma),
    .gap_o        (gap)
  );

  // Table order follows trans_e
  assign tbl[TR_WR]      = cfg_wr_idle_i;
  assign tbl[TR_WW]      = cfg_ww_idle_i;
  assign tbl[TR_RW_SAME] = cfg_rw_same_i;
  assign tbl[TR_RW_DIFF] = cfg_rw_diff_i;
  assign tbl[TR_RR_SAME] = cfg_rr_same_i;
  assign tbl[TR_RR_DIFF] = cfg_rr_diff_i;

  // Per-space fields come from the ended access's space
  for (genvar k = 0; k < NUM_CAT; k++) begin : g_fld
    iai_field_mux #(.NUM(NUM_SPACES), .W(IDLE_W)) u_mux (
      .tbl_i (tbl[k]),
      .idx_i (prev_space),
      .val_o (fld[k])
    );
  end

  iai_field_mux #(.NUM(NUM_SPACES), .W(1)) u_wm_mux (
    .tbl_i (cfg_wait_mode_i),
    .idx_i (prev_space),
    .val_o (wm_sel)
  );

  iai_rule_sel #(.W(IDLE_W)) u_sel (
    .prev_write_i  (prev_write),
    .prev_dma_i    (prev_dma),
    .prev_wm_i     (wm_sel),
    .same_space_i  (prev_space == nxt_space_i),
    .nxt_write_i   (nxt_write_i),
    .nxt_dev_out_i (nxt_dev_out_i),
    .dma_all_i     (cfg_dma_all_i),
    .dma_idle_i    (cfg_dma_idle_i),
    .fld_i         (fld),
    .need_o        (need),
    .dma_hit_o     (dma_hit),
    .cat_o         (cat)
  );

  assign idle_cnt_o = prev_vld ? need : '0;
  assign remain_o   = (idle_cnt_o > gap) ? (idle_cnt_o - gap) : '0;
  assign stall_o    = req_i && (remain_o != '0);

  assert_cat_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cat < 3'(NUM_CAT));
  assert_dma_floor_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_vld && dma_hit) |-> idle_cnt_o >= cfg_dma_idle_i);
  assert_wm_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_vld && !wm_sel) |-> idle_cnt_o != '0);
  assert_first_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(end_valid_i) && req_i && idle_cnt_o != '0) |-> stall_o);
  assert_countdown_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remain_o != '0 && !end_valid_i) |=>
      (!$stable(idle_cnt_o) || remain_o == $past(remain_o) - IDLE_W'(1)));
endmodule

// File: tb/iai_idle_inserter_test.sv
module iai_idle_inserter_test;
  localparam int PERIOD = 10;
  localparam int NS = 8;
  localparam int W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic end_valid = 0, end_write = 0, end_dma = 0;
  logic [2:0] end_space = 0, nxt_space = 0;
  logic req = 0, nxt_write = 0, nxt_dev_out = 0;
  logic [NS*W-1:0] c_wr = 0, c_ww = 0, c_rws = 0, c_rwd = 0, c_rrs = 0, c_rrd = 0;
  logic [NS-1:0] c_wm = '1;
  logic [W-1:0] c_dma = 0;
  logic c_dma_all = 0;
  logic stall;
  logic [W-1:0] idle_cnt, remain;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  bit m_vld = 0, m_pw = 0, m_pd = 0;
  logic [2:0] m_ps = 0;
  int m_gap = 0;

  always #(PERIOD/2) clk = ~clk;

  iai_idle_inserter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .end_valid_i(end_valid), .end_write_i(end_write), .end_space_i(end_space),
    .end_dma_ext_i(end_dma), .req_i(req), .nxt_write_i(nxt_write),
    .nxt_space_i(nxt_space), .nxt_dev_out_i(nxt_dev_out),
    .cfg_wr_idle_i(c_wr), .cfg_ww_idle_i(c_ww), .cfg_rw_same_i(c_rws),
    .cfg_rw_diff_i(c_rwd), .cfg_rr_same_i(c_rrs), .cfg_rr_diff_i(c_rrd),
    .cfg_wait_mode_i(c_wm), .cfg_dma_idle_i(c_dma), .cfg_dma_all_i(c_dma_all),
    .stall_o(stall), .idle_cnt_o(idle_cnt), .remain_o(remain)
  );

  function automatic int fget(logic [NS*W-1:0] t, int s);
    return int'(t[s*W +: W]);
  endfunction

  function automatic int exp_need();
    int n;
    bit same;
    if (!m_vld) return 0;
    same = (m_ps == nxt_space);
    if (m_pw && !nxt_write)      n = fget(c_wr, m_ps);
    else if (m_pw && nxt_write)  n = fget(c_ww, m_ps);
    else if (nxt_write)          n = same ? fget(c_rws, m_ps) : fget(c_rwd, m_ps);
    else                         n = same ? fget(c_rrs, m_ps) : fget(c_rrd, m_ps);
    if (m_pd && (c_dma_all || nxt_dev_out) && int'(c_dma) > n) n = int'(c_dma);
    if (!c_wm[m_ps] && n == 0) n = 1;
    return n;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Inputs are set at the falling edge; compare, then advance one cycle
  task automatic tick(string tag);
    int n, r;
    #1;
    n = exp_need();
    r = (n > m_gap) ? n - m_gap : 0;
    chk(tag, "idle_cnt", int'(idle_cnt), n);
    chk(tag, "remain", int'(remain), r);
    chk(tag, "stall", int'(stall), int'(req && r != 0));
    @(posedge clk);
    if (rst_n) begin
      if (end_valid) begin
        m_vld = 1; m_pw = end_write; m_ps = end_space; m_pd = end_dma; m_gap = 0;
      end else if (m_gap < 7) m_gap++;
    end
    @(negedge clk);
  endtask

  // End an access, then hold the next request for n cycles
  task automatic pair(bit pw, int ps, bit pd, bit nw, int ns, bit dev, int n, string tag);
    end_valid = 1; end_write = pw; end_space = 3'(ps); end_dma = pd;
    req = 0; nxt_write = nw; nxt_space = 3'(ns); nxt_dev_out = dev;
    tick(tag);
    end_valid = 0; req = 1;
    for (int i = 0; i < n; i++) tick(tag);
    req = 0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    req = 1;
    tick("R10");   // in reset
    tick("R10");
    rst_n = 1;
    @(negedge clk);
    tick("R10");   // no prior access yet
    tick("R10");
    req = 0;

    c_wr[2*W +: W] = 3; c_ww[2*W +: W] = 5;
    c_rws[2*W +: W] = 2; c_rwd[2*W +: W] = 6; c_rwd[5*W +: W] = 1;
    c_rrs[2*W +: W] = 4; c_rrd[2*W +: W] = 7; c_rrd[5*W +: W] = 0;
    pair(1, 2, 0, 0, 2, 0, 5, "R1");   // write->read: 3
    pair(1, 2, 0, 1, 5, 0, 7, "R1");   // write->write: 5
    pair(0, 2, 0, 1, 2, 0, 4, "R2");   // read->write same: 2
    pair(0, 2, 0, 1, 5, 0, 8, "R2");   // read->write diff: 6
    pair(0, 5, 0, 1, 2, 0, 3, "R4");   // from space 5: 1
    pair(0, 2, 0, 0, 2, 0, 6, "R3");   // read->read same: 4
    pair(0, 2, 0, 0, 1, 0, 9, "R3");   // read->read diff: 7
    pair(0, 5, 0, 0, 2, 0, 2, "R9");   // count 0: no stall
    c_wm[5] = 0;
    pair(0, 5, 0, 0, 2, 0, 3, "R7");   // wait-mode floor: 1
    pair(0, 2, 0, 0, 5, 0, 9, "R4");   // wm of space 5 ignored
    c_wm[5] = 1;
    c_dma = 4; c_dma_all = 0;
    pair(0, 5, 1, 0, 2, 0, 3, "R5");   // not device output: 0
    pair(0, 5, 1, 0, 2, 1, 6, "R5");   // device output: 4
    c_dma_all = 1;
    pair(0, 5, 1, 1, 2, 0, 6, "R6");   // any access: 4
    pair(0, 2, 1, 1, 5, 0, 8, "R8");   // max(6,4)=6
    pair(0, 2, 1, 1, 2, 0, 5, "R8");   // max(2,4)=4
    c_dma_all = 0;
    // long idle before the request
    end_valid = 1; end_write = 0; end_space = 2; end_dma = 0;
    nxt_write = 0; nxt_space = 1; req = 0;
    tick("R11");
    end_valid = 0;
    for (int i = 0; i < 10; i++) tick("R11");
    req = 1;
    tick("R11");
    tick("R11");
    req = 0;
    // partial idle then request
    end_valid = 1;
    tick("R12");
    end_valid = 0;
    tick("R12"); tick("R12");
    req = 1;
    for (int i = 0; i < 6; i++) tick("R12");

    // random traffic
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc % 250 == 0) begin
        c_wr = 24'($urandom); c_ww = 24'($urandom); c_rws = 24'($urandom);
        c_rwd = 24'($urandom); c_rrs = 24'($urandom); c_rrd = 24'($urandom);
        c_wm = 8'($urandom); c_dma = 3'($urandom); c_dma_all = 1'($urandom);
      end
      end_valid = ($urandom % 6) == 0;
      end_write = 1'($urandom); end_space = 3'($urandom); end_dma = 1'($urandom);
      req = 1'($urandom);
      if ($urandom % 4 == 0) begin
        nxt_write = 1'($urandom); nxt_space = 3'($urandom); nxt_dev_out = 1'($urandom);
      end
      tick("R8");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule